// File: doc/BRIEF.md
# Physical Memory Attribute Checker

This block holds a small bank of machine-mode registers that carve physical memory into regions. Every region carries read, write and execute permissions and two further attributes: whether atomic operations are allowed and whether the region may be cached. On the check side, a physical address and an access kind go in. Out come three results: an access fault, an atomic-allowed flag, and a flag that routes the access to the uncached MMIO path.

The check has no privilege input. It applies to every access, machine mode included, and a lock bit gives no exemption. Lock only freezes the registers. A region is found in one of two ways. In top-of-range form, an entry's address and the address of the entry before it bound the region. In naturally aligned power-of-two form, a single address register encodes both base and size. Both forms resolve at a 64-byte granule. A parameter selects between two response styles: results in the same cycle as the request, or results registered for the next cycle.

Top module: `pma_checker`

## Requirements
- R1: Config byte fields are bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two), bit 5 atomic, bit 6 cacheable, bit 7 lock. Register index k < 4 is a config register holding entries 4k..4k+3, with entry 4k+j in bits 8j+7:8j. Index 4+e is the address register of entry e and holds physical address bits 35:2. Reads are combinational and zero-extended, and an index of 20 or more reads zero.
- R2: A write whose privilege input is not 3 (machine) changes no register.
- R3: A locked entry ignores writes to its config byte and to its address register. The address register of entry e is also frozen while entry e+1 is locked in top-of-range mode.
- R4: A top-of-range entry e matches when prev <= paddr[35:6] < addr[e][33:4]. Here prev is addr[e-1][33:4], and it is 0 for entry 0.
- R5: A power-of-two entry treats address bits 2:0 as ones. With t trailing ones, it covers 2^(t+3) bytes aligned to that size. The match uses the current address and config, in whichever order they were written.
- R6: An entry in mode off or in the four-byte mode never matches.
- R7: When several entries match, the lowest-numbered one decides all outputs.
- R8: Access kinds are 0 load, 1 store, 2 fetch and 3 atomic. A matched access faults when the entry lacks read, write or execute respectively. An atomic access also faults unless the entry grants read, write and atomic. This holds in every privilege and lock state.
- R9: On a match, the atomic flag is the entry's atomic bit and the MMIO flag is the inverse of its cacheable bit. With no match the outputs are fault 0, atomic 0 and MMIO 1.
- R10: With the registered response parameter at 1, outputs show the result for the previous cycle's inputs and reset to fault 0, atomic 0, MMIO 1. With it at 0, outputs follow the inputs in the same cycle.
- R11: After reset every config and address register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | Register write strobe |
| csr_priv_i | input | 2 | Privilege of the writer, 3 is machine |
| csr_idx_i | input | 5 | Register index |
| csr_wdata_i | input | 64 | Write data |
| csr_rdata_o | output | 64 | Read data for csr_idx_i |
| chk_paddr_i | input | 36 | Physical address under check |
| chk_type_i | input | 2 | Access kind |
| fault_o | output | 1 | Access fault |
| atomic_o | output | 1 | Atomic operations allowed |
| mmio_o | output | 1 | Route to uncached path |

## Verification
The bench builds two instances with the default sizes (16 entries, 4 entries per config register, 36-bit addresses, 64-byte granule). One instance uses the registered response and the other the same-cycle response, so both timing variants are checked against the same expected values. Keeping the full 16 entries brings into reach the cases that involve neighbouring entries: a lock held by the next entry, top-of-range bounds taken from the previous entry, and priority among overlapping regions. Random register contents are confined to a 64 KiB window so that random addresses hit regions often.

// File: rtl/pma_pkg.sv
package pma_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } pma_mode_e;

  typedef struct packed {
    logic      lock;
    logic      cache;
    logic      amo;
    pma_mode_e mode;
    logic      x;
    logic      w;
    logic      r;
  } pma_cfg_t;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;
  localparam logic [1:0] ACC_AMO   = 2'd3;
  localparam logic [1:0] PRIV_M    = 2'd3;
endpackage

// File: rtl/pma_regs.sv
module pma_regs
  import pma_pkg::*;
#(
  parameter int N         = 16,
  parameter int EPC       = 4,
  parameter int AW        = 34,
  parameter int DW        = 64,
  parameter int GRAN_LOG2 = 6,
  parameter int IW        = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 csr_we_i,
  input  logic [1:0]           csr_priv_i,
  input  logic [IW-1:0]        csr_idx_i,
  input  logic [DW-1:0]        csr_wdata_i,
  output logic [DW-1:0]        csr_rdata_o,
  output pma_cfg_t [N-1:0]     cfg_o,
  output logic [N-1:0][AW-1:0] addr_o,
  output logic [N-1:0][AW-1:0] mask_o
);
  localparam int NCFG = N / EPC;
  localparam int LOWB = GRAN_LOG2 - 3;
  localparam logic [AW-1:0] LOW_ONES = (AW'(1) << LOWB) - AW'(1);

  pma_cfg_t [N-1:0]     cfg_q;
  logic [N-1:0][AW-1:0] addr_q, mask_q;
  logic [N-1:0]         addr_lock;
  logic                 wr_ok;

  function automatic logic [AW-1:0] napot_mask(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    r = a | LOW_ONES;
    return r ^ (r + AW'(1));
  endfunction

  assign wr_ok = csr_we_i && (csr_priv_i == PRIV_M);

  for (genvar e = 0; e < N; e++) begin : g_lock
    if (e + 1 < N) begin : g_nxt
      assign addr_lock[e] = cfg_q[e].lock | (cfg_q[e+1].lock & (cfg_q[e+1].mode == MODE_TOR));
    end else begin : g_last
      assign addr_lock[e] = cfg_q[e].lock;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      addr_q <= '0;
      for (int e = 0; e < N; e++) mask_q[e] <= napot_mask('0);
    end else if (wr_ok) begin
      for (int e = 0; e < N; e++) begin
        if (csr_idx_i == IW'(e / EPC) && !cfg_q[e].lock) begin
          cfg_q[e]  <= pma_cfg_t'(csr_wdata_i[8*(e%EPC) +: 8]);
          mask_q[e] <= napot_mask(addr_q[e]);
        end
        if (csr_idx_i == IW'(NCFG + e) && !addr_lock[e]) begin
          addr_q[e] <= csr_wdata_i[AW-1:0];
          mask_q[e] <= napot_mask(csr_wdata_i[AW-1:0]);
        end
      end
    end
  end

  always_comb begin
    csr_rdata_o = '0;
    for (int c = 0; c < NCFG; c++)
      if (csr_idx_i == IW'(c))
        for (int j = 0; j < EPC; j++) csr_rdata_o[8*j +: 8] = cfg_q[c*EPC+j];
    for (int e = 0; e < N; e++)
      if (csr_idx_i == IW'(NCFG + e)) csr_rdata_o[AW-1:0] = addr_q[e];
  end

  assign cfg_o  = cfg_q;
  assign addr_o = addr_q;
  assign mask_o = mask_q;

  assert_low_priv_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_priv_i != PRIV_M) |=> ($stable(cfg_q) && $stable(addr_q)));

  for (genvar e = 0; e < N; e++) begin : g_lock_chk
    assert_lock_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_q[e].lock |=> ($stable(cfg_q[e]) && $stable(addr_q[e])));
  end
endmodule

// File: rtl/pma_match.sv
module pma_match
  import pma_pkg::*;
#(
  parameter int N         = 16,
  parameter int AW        = 34,
  parameter int PA_W      = 36,
  parameter int GRAN_LOG2 = 6
) (
  input  pma_cfg_t [N-1:0]     cfg_i,
  input  logic [N-1:0][AW-1:0] addr_i,
  input  logic [N-1:0][AW-1:0] mask_i,
  input  logic [PA_W-1:0]      paddr_i,
  input  logic [1:0]           type_i,
  output logic                 hit_o,
  output logic                 fault_o,
  output logic                 amo_o,
  output logic                 mmio_o
);
  localparam int SH   = GRAN_LOG2 - 2;
  localparam int LOWB = GRAN_LOG2 - 3;
  localparam logic [AW-1:0] LOW_ONES = (AW'(1) << LOWB) - AW'(1);

  logic [AW-1:0] pa_w;
  logic [N-1:0]  hit_vec;
  pma_cfg_t      sel;
  logic          ok;

  assign pa_w = paddr_i[PA_W-1:2];

  for (genvar e = 0; e < N; e++) begin : g_ent
    logic [AW-1:0] lo;
    logic          tor_hit, napot_hit;
    if (e == 0) begin : g_first
      assign lo = '0;
    end else begin : g_rest
      assign lo = addr_i[e-1];
    end
    assign tor_hit   = ((pa_w >> SH) >= (lo >> SH)) && ((pa_w >> SH) < (addr_i[e] >> SH));
    assign napot_hit = ((pa_w ^ (addr_i[e] | LOW_ONES)) & ~mask_i[e]) == '0;
    assign hit_vec[e] = (cfg_i[e].mode == MODE_TOR)   ? tor_hit :
                        (cfg_i[e].mode == MODE_NAPOT) ? napot_hit : 1'b0;
  end

  // highest index first so the lowest matching entry is left in sel
  always_comb begin
    sel = '0;
    for (int e = N - 1; e >= 0; e--)
      if (hit_vec[e]) sel = cfg_i[e];
  end

  always_comb begin
    unique case (type_i)
      ACC_LOAD:  ok = sel.r;
      ACC_STORE: ok = sel.w;
      ACC_FETCH: ok = sel.x;
      default:   ok = sel.r & sel.w & sel.amo;
    endcase
  end

  assign hit_o   = |hit_vec;
  assign fault_o = hit_o & ~ok;
  assign amo_o   = hit_o & sel.amo;
  assign mmio_o  = ~(hit_o & sel.cache);
endmodule

// File: rtl/pma_checker.sv
module pma_checker
  import pma_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ENT_PER_CFG = 4,
  parameter int PA_W        = 36,
  parameter int DATA_W      = 64,
  parameter int GRAN_LOG2   = 6,
  parameter bit REG_RESP    = 1'b1,
  localparam int AW         = PA_W - 2,
  localparam int NCFG       = NUM_ENTRIES / ENT_PER_CFG,
  localparam int IW         = $clog2(NCFG + NUM_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_we_i,
  input  logic [1:0]        csr_priv_i,
  input  logic [IW-1:0]     csr_idx_i,
  input  logic [DATA_W-1:0] csr_wdata_i,
  output logic [DATA_W-1:0] csr_rdata_o,
  input  logic [PA_W-1:0]   chk_paddr_i,
  input  logic [1:0]        chk_type_i,
  output logic              fault_o,
  output logic              atomic_o,
  output logic              mmio_o
);
  pma_cfg_t [NUM_ENTRIES-1:0]     cfg;
  logic [NUM_ENTRIES-1:0][AW-1:0] addr, mask;
  logic m_hit, m_fault, m_amo, m_mmio;

  pma_regs #(
    .N(NUM_ENTRIES), .EPC(ENT_PER_CFG), .AW(AW), .DW(DATA_W),
    .GRAN_LOG2(GRAN_LOG2), .IW(IW)
  ) u_regs (
    .clk_i, .rst_ni, .csr_we_i, .csr_priv_i, .csr_idx_i, .csr_wdata_i,
    .csr_rdata_o, .cfg_o(cfg), .addr_o(addr), .mask_o(mask)
  );

  pma_match #(
    .N(NUM_ENTRIES), .AW(AW), .PA_W(PA_W), .GRAN_LOG2(GRAN_LOG2)
  ) u_match (
    .cfg_i(cfg), .addr_i(addr), .mask_i(mask), .paddr_i(chk_paddr_i),
    .type_i(chk_type_i), .hit_o(m_hit), .fault_o(m_fault), .amo_o(m_amo),
    .mmio_o(m_mmio)
  );

  if (REG_RESP) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fault_o  <= 1'b0;
        atomic_o <= 1'b0;
        mmio_o   <= 1'b1;
      end else begin
        fault_o  <= m_fault;
        atomic_o <= m_amo;
        mmio_o   <= m_mmio;
      end
    end

    assert_resp_delay_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      m_fault |=> fault_o);
    assert_nohit_default_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !m_hit |=> (mmio_o && !atomic_o && !fault_o));
  end else begin : g_comb
    assign fault_o  = m_fault;
    assign atomic_o = m_amo;
    assign mmio_o   = m_mmio;

    assert_nohit_default_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !m_hit |-> (mmio_o && !atomic_o && !fault_o));
  end
endmodule

// File: tb/pma_checker_bench.sv
module pma_checker_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_priv = 2'd3;
  logic [4:0]  csr_idx = '0;
  logic [63:0] csr_wdata = '0;
  logic [35:0] paddr = '0;
  logic [1:0]  ctype = '0;
  logic [63:0] rd_r, rd_c;
  logic f_r, a_r, m_r, f_c, a_c, m_c;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0]  m_cfg  [16];
  logic [33:0] m_addr [16];

  always #4 clk = ~clk;

  pma_checker #(.REG_RESP(1'b1)) u_pma_checker (
    .clk_i(clk), .rst_ni, .csr_we_i(csr_we), .csr_priv_i(csr_priv), .csr_idx_i(csr_idx),
    .csr_wdata_i(csr_wdata), .csr_rdata_o(rd_r), .chk_paddr_i(paddr), .chk_type_i(ctype),
    .fault_o(f_r), .atomic_o(a_r), .mmio_o(m_r));

  pma_checker #(.REG_RESP(1'b0)) u_pma_checker_comb (
    .clk_i(clk), .rst_ni, .csr_we_i(csr_we), .csr_priv_i(csr_priv), .csr_idx_i(csr_idx),
    .csr_wdata_i(csr_wdata), .csr_rdata_o(rd_c), .chk_paddr_i(paddr), .chk_type_i(ctype),
    .fault_o(f_c), .atomic_o(a_c), .mmio_o(m_c));

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int e = 0; e < 16; e++) begin m_cfg[e] = '0; m_addr[e] = '0; end
  endfunction

  function automatic void model_wr(input int idx, input logic [63:0] d, input logic [1:0] p);
    if (p != 2'd3) return;
    if (idx < 4) begin
      for (int j = 0; j < 4; j++)
        if (!m_cfg[4*idx+j][7]) m_cfg[4*idx+j] = d[8*j +: 8];
    end else if (idx < 20) begin
      int e = idx - 4;
      bit lk = m_cfg[e][7] || (e < 15 && m_cfg[e+1][7] && m_cfg[e+1][4:3] == 2'd1);
      if (!lk) m_addr[e] = d[33:0];
    end
  endfunction

  function automatic logic [63:0] model_rd(input int idx);
    if (idx < 4) return {32'd0, m_cfg[4*idx+3], m_cfg[4*idx+2], m_cfg[4*idx+1], m_cfg[4*idx]};
    if (idx < 20) return 64'(m_addr[idx-4]);
    return 64'd0;
  endfunction

  function automatic logic [2:0] model_chk(input logic [35:0] pa, input logic [1:0] ty);
    longint unsigned pg, pw, lo, hi, r;
    pg = 64'(pa) >> 6;
    pw = 64'(pa) >> 2;
    for (int e = 0; e < 16; e++) begin
      bit hit = 0;
      bit ok;
      logic [7:0] c = m_cfg[e];
      if (c[4:3] == 2'd1) begin
        lo = (e == 0) ? 0 : (64'(m_addr[e-1]) >> 4);
        hi = 64'(m_addr[e]) >> 4;
        hit = (pg >= lo) && (pg < hi);
      end else if (c[4:3] == 2'd3) begin
        int t = 0;
        r = 64'(m_addr[e]) | 64'd7;
        while (t < 34 && r[t]) t++;
        hit = ((pw >> (t + 1)) == (r >> (t + 1)));
      end
      if (hit) begin
        case (ty)
          2'd0: ok = c[0];
          2'd1: ok = c[1];
          2'd2: ok = c[2];
          default: ok = c[0] & c[1] & c[5];
        endcase
        return {!ok, c[5], !c[6]};
      end
    end
    return 3'b001;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    csr_we = 1'b0;
    model_clear();
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input int idx, input logic [63:0] d, input logic [1:0] p);
    @(negedge clk);
    csr_we = 1'b1; csr_idx = 5'(idx); csr_wdata = d; csr_priv = p;
    @(negedge clk);
    csr_we = 1'b0;
    model_wr(idx, d, p);
  endtask

  task automatic rd(input int idx, input string tag);
    @(negedge clk);
    csr_idx = 5'(idx);
    #1;
    cmp(tag, rd_r, model_rd(idx));
    cmp(tag, rd_c, model_rd(idx));
  endtask

  task automatic chk(input logic [35:0] pa, input logic [1:0] ty, input string tag);
    logic [2:0] ex;
    @(negedge clk);
    paddr = pa; ctype = ty;
    ex = model_chk(pa, ty);
    #1;
    cmp({tag, " same-cycle R10"}, {61'd0, f_c, a_c, m_c}, {61'd0, ex});
    @(negedge clk);
    cmp({tag, " registered R10"}, {61'd0, f_r, a_r, m_r}, {61'd0, ex});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    model_clear();
    do_reset();
    // R11 reset values, R10 registered reset outputs
    #1;
    cmp("R10 reset outputs", {61'd0, f_r, a_r, m_r}, 64'd1);
    for (int i = 0; i < 20; i++) rd(i, "R11 reset readback");
    chk(36'h0, 2'd0, "R9 no match after reset");

    // R5 power-of-two region 0x1000..0x1FFF, R X cacheable
    wr(4, 64'h5FF, 2'd3);
    wr(0, 64'h5D, 2'd3);
    chk(36'h1000, 2'd0, "R5 napot load");
    chk(36'h1FC0, 2'd1, "R8 napot store fault");
    chk(36'h1FFF, 2'd2, "R5 napot fetch top");
    chk(36'h2000, 2'd0, "R5 napot above");
    chk(36'h0FFF, 2'd0, "R5 napot below");
    // R5 config written before address: region 0x8000..0x80FF
    wr(0, 64'h1B5D, 2'd3);
    wr(5, 64'h201F, 2'd3);
    chk(36'h80F0, 2'd1, "R5 cfg-then-addr store");
    chk(36'h8100, 2'd1, "R5 cfg-then-addr above");
    // R7 overlapping entry 2 over 0..0xFFFF, RWX atomic, uncached
    wr(6, 64'h1FFF, 2'd3);
    wr(0, 64'h3F1B5D, 2'd3);
    chk(36'h1000, 2'd1, "R7 lowest entry decides");
    chk(36'h3000, 2'd1, "R7 later entry");
    chk(36'h3000, 2'd3, "R8 atomic allowed");
    chk(36'h1000, 2'd3, "R8 atomic faults");
    // R4 top-of-range entry 5 between entry 4 and itself
    wr(8, 64'h4000, 2'd3);
    wr(9, 64'h4400, 2'd3);
    wr(1, 64'h4900, 2'd3);
    chk(36'h10000, 2'd0, "R4 tor bottom");
    chk(36'h10FC0, 2'd0, "R4 tor top granule");
    chk(36'h11000, 2'd0, "R4 tor upper bound excluded");
    chk(36'h0FFC0, 2'd1, "R9 below tor via entry2");
    // R6 four-byte mode never matches
    wr(10, 64'h5000, 2'd3);
    wr(1, 64'h114900, 2'd3);
    chk(36'h14000, 2'd0, "R6 na4 no match");
    // R2 lower privilege writes ignored
    wr(1, 64'h0, 2'd1);
    wr(9, 64'h0, 2'd0);
    rd(1, "R2 cfg unchanged");
    rd(9, "R2 addr unchanged");
    chk(36'h10000, 2'd0, "R2 region still active");
    // R3 lock: entry 7 tor locked, read only
    wr(11, 64'h5100, 2'd3);
    wr(1, 64'h89114900, 2'd3);
    wr(1, 64'h0, 2'd3);
    wr(10, 64'h1, 2'd3);
    wr(11, 64'h2, 2'd3);
    rd(1, "R3 locked byte kept");
    rd(10, "R3 addr frozen by next lock");
    rd(11, "R3 addr frozen by own lock");
    chk(36'h14000, 2'd1, "R8 locked entry still checked");
    chk(36'h14000, 2'd0, "R3 locked region read");
    rd(25, "R1 out of range read");
    rd(0, "R1 cfg layout");

    // R4 entry 0 lower bound is zero
    do_reset();
    wr(4, 64'h40, 2'd3);
    wr(0, 64'h49, 2'd3);
    chk(36'h0, 2'd0, "R4 entry0 from zero");
    chk(36'hC0, 2'd0, "R4 entry0 top");
    chk(36'h100, 2'd0, "R4 entry0 bound");

    // constrained random rounds
    for (int rnd = 0; rnd < 10; rnd++) begin
      do_reset();
      for (int k = 0; k < 40; k++) begin
        int idx = $urandom_range(0, 21);
        logic [63:0] d;
        logic [1:0] p;
        p = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'd3;
        if (idx < 4) begin
          d = {$urandom, $urandom};
          if ($urandom_range(0, 5) != 0) d &= 64'h7F7F7F7F;
        end else if ($urandom_range(0, 7) == 0) begin
          d = {$urandom, $urandom};
        end else begin
          d = 64'($urandom_range(0, 16'h3FFF));
        end
        wr(idx, d, p);
      end
      for (int i = 0; i < 21; i++) rd(i, "R1 random readback");
      for (int k = 0; k < 200; k++) begin
        logic [35:0] pa;
        pa = ($urandom_range(0, 9) == 0) ? 36'({$urandom, $urandom}) : 36'($urandom_range(0, 16'hFFFF));
        chk(pa, 2'($urandom_range(0, 3)), "R7 R8 R9 random");
      end
    end
    finish_run();
  end
endmodule